// File: doc/BRIEF.md
# Thermal Sensor Register and Alarm Unit

This block holds the register file and the limit-comparison logic of a digital temperature sensor of the kind fitted to memory modules. A sample port delivers a 13-bit two's-complement temperature code in units of 1/16 °C. Each accepted sample is stored and checked against three programmable limits: critical, upper and lower. Hysteresis is programmable. The comparison results appear as flag bits in the temperature register and, combined, on an event pin.

A parallel port reaches eight 16-bit registers through a 3-bit pointer. Writes are synchronous and reads are combinational. The configuration register provides two sticky lock bits, a shutdown bit and a mode that reports only the critical alarm. The serial bus slave and the converter that produce the samples live outside this block.

Top module: `tsense_alarm_top`

## Requirements
- R1: Pointer values select the registers in this order: 0 capability, 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit, 5 temperature, 6 manufacturer ID, 7 device ID. After reset the capability register reads {13'b0, EXT_RANGE, 1'b0, 1'b1}, the identity registers read MFG_ID and DEV_ID, and every other register reads 0.
- R2: Writes to pointers 0, 5, 6 and 7 have no effect. Configuration bits 15:11, 5:3 and 1:0 always read 0. Limit bits 15:13 always read 0, and limit bits 12:0 store write data bits 12:0.
- R3: When sample_valid is high and shutdown is clear, the temperature register bits 12:0 show the sample code on the cycle after the clock edge.
- R4: Temperature bit 15 (critical flag) sets when a sample is at or above the critical limit. Once set, it stays set while samples are at or above the critical limit minus the hysteresis, and it clears on the first sample below that value.
- R5: Temperature bit 14 (upper flag) follows the same rule against the upper limit.
- R6: Temperature bit 13 (lower flag) sets when a sample is below the lower limit. Once set, it stays set while samples are below the lower limit plus the hysteresis.
- R7: Configuration bits 10:9 select a hysteresis of 0, 24, 48 or 96 LSB for codes 0 to 3. All comparisons are signed.
- R8: While configuration bit 2 (critical-only) is set, the upper and lower flags read 0 and do not drive the event pin. Samples accepted in this mode clear those two flags.
- R9: While configuration bit 6 is set, writes to the critical limit are ignored.
- R10: While configuration bit 7 is set, writes to the upper and lower limits are ignored. A configuration write changes bits 10:9 only if both lock bits were clear before that write.
- R11: Lock bits 6 and 7 can be set by a write but are cleared only by reset.
- R12: While configuration bit 8 (shutdown) is set, samples are ignored, and the temperature value and all flags hold.
- R13: event_o is high exactly when the critical flag is set, or when critical-only mode is clear and the upper or lower flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new temperature code is present |
| sample_code | input | 13 | Two's-complement temperature, 1/16 °C per LSB |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register pointer |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the register selected by reg_addr |
| event_o | output | 1 | Combined alarm output |

## Verification
The hardest condition to reach is a flag that is set while the temperature sits inside the hysteresis band below a limit. The flag's value there depends on the path the temperature took to get there. The stimulus ramps the sample code upward through each limit and then back down in small steps, once for every hysteresis code and for the lower limit in the opposite direction. This places samples on, just inside and just outside each band edge. The sweeps are then repeated after the locks are set, to show that the hysteresis setting survived configuration writes that tried to change it.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int REG_W  = 16;
    localparam int CODE_W = 13;
    localparam int PTR_W  = 3;
    localparam int HYS_W  = 7;

    typedef enum logic [PTR_W-1:0] {
        PTR_CAP  = 3'd0,
        PTR_CFG  = 3'd1,
        PTR_HI   = 3'd2,
        PTR_LO   = 3'd3,
        PTR_CRIT = 3'd4,
        PTR_TEMP = 3'd5,
        PTR_MFG  = 3'd6,
        PTR_DEV  = 3'd7
    } ptr_e;

    // configuration bit positions that software decodes
    localparam int CB_CRIT_ONLY = 2;
    localparam int CB_LOCK_CRIT = 6;
    localparam int CB_LOCK_WIN  = 7;
    localparam int CB_SHDN      = 8;
    localparam int CB_HYS_LSB   = 9;

    typedef struct packed {
        logic [1:0] hyst;
        logic       shdn;
        logic       lock_win;
        logic       lock_crit;
        logic       crit_only;
    } cfg_t;

    typedef struct packed {
        logic crit;
        logic hi;
        logic lo;
    } flags_t;

    function automatic logic [HYS_W-1:0] hyst_lsb(input logic [1:0] code);
        case (code)
            2'd0:    return 7'd0;
            2'd1:    return 7'd24;
            2'd2:    return 7'd48;
            default: return 7'd96;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] cfg_word(input cfg_t c);
        return {5'b0, c.hyst, c.shdn, c.lock_win, c.lock_crit, 3'b0, c.crit_only, 2'b0};
    endfunction

    function automatic logic [REG_W-1:0] lim_word(input logic [CODE_W-1:0] v);
        return {{(REG_W-CODE_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tsense_cfg_regs.sv
module tsense_cfg_regs
    import tsense_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [PTR_W-1:0]    addr,
    input  logic [REG_W-1:0]    wdata,
    output cfg_t                cfg_q,
    output logic [CODE_W-1:0]   hi_q,
    output logic [CODE_W-1:0]   lo_q,
    output logic [CODE_W-1:0]   crit_q
);

    ptr_e ptr;
    logic any_lock;

    assign ptr      = ptr_e'(addr);
    assign any_lock = cfg_q.lock_crit | cfg_q.lock_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            crit_q <= '0;
        end else if (we) begin
            case (ptr)
                PTR_CFG: begin
                    cfg_q.crit_only <= wdata[CB_CRIT_ONLY];
                    cfg_q.shdn      <= wdata[CB_SHDN];
                    cfg_q.lock_crit <= cfg_q.lock_crit | wdata[CB_LOCK_CRIT];
                    cfg_q.lock_win  <= cfg_q.lock_win  | wdata[CB_LOCK_WIN];
                    if (!any_lock)
                        cfg_q.hyst <= wdata[CB_HYS_LSB +: 2];
                end
                PTR_HI:   if (!cfg_q.lock_win)  hi_q   <= wdata[CODE_W-1:0];
                PTR_LO:   if (!cfg_q.lock_win)  lo_q   <= wdata[CODE_W-1:0];
                PTR_CRIT: if (!cfg_q.lock_crit) crit_q <= wdata[CODE_W-1:0];
                default: ;
            endcase
        end
    end

    // R9
    crit_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock_crit && we && ptr == PTR_CRIT) |=> $stable(crit_q));

    // R10
    win_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock_win && we && (ptr == PTR_HI || ptr == PTR_LO)) |=> ($stable(hi_q) && $stable(lo_q)));

    // R10
    hyst_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        any_lock |=> $stable(cfg_q.hyst));

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock_crit || cfg_q.lock_win) |=>
            (cfg_q.lock_crit >= $past(cfg_q.lock_crit) && cfg_q.lock_win >= $past(cfg_q.lock_win)));

endmodule

// File: rtl/tsense_limit_cmp.sv
module tsense_limit_cmp
    import tsense_pkg::*;
#(
    parameter bit BELOW = 1'b0,
    parameter int W     = CODE_W
) (
    input  logic [W-1:0] temp,
    input  logic [W-1:0] limit,
    input  logic [1:0]   hyst_code,
    input  logic         prev,
    output logic         next
);

    localparam int XW = W + 2;

    logic signed [XW-1:0] t_s;
    logic signed [XW-1:0] l_s;
    logic signed [XW-1:0] h_s;

    assign t_s = {{2{temp[W-1]}}, temp};
    assign l_s = {{2{limit[W-1]}}, limit};
    assign h_s = {{(XW-HYS_W){1'b0}}, hyst_lsb(hyst_code)};

    generate
        if (BELOW) begin : g_below
            logic signed [XW-1:0] release_lvl;
            assign release_lvl = l_s + h_s;
            assign next = prev ? (t_s < release_lvl) : (t_s < l_s);
        end else begin : g_above
            logic signed [XW-1:0] release_lvl;
            assign release_lvl = l_s - h_s;
            assign next = prev ? (t_s >= release_lvl) : (t_s >= l_s);
        end
    endgenerate

endmodule

// File: rtl/tsense_alarm_eval.sv
module tsense_alarm_eval
    import tsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  cfg_t              cfg,
    input  logic [CODE_W-1:0] hi_lim,
    input  logic [CODE_W-1:0] lo_lim,
    input  logic [CODE_W-1:0] crit_lim,
    output logic [CODE_W-1:0] temp_q,
    output flags_t            flags_q
);

    flags_t nxt;
    logic   accept;

    assign accept = smp_valid & ~cfg.shdn;

    tsense_limit_cmp #(.BELOW(1'b0), .W(CODE_W)) u_crit (
        .temp(smp_code), .limit(crit_lim), .hyst_code(cfg.hyst),
        .prev(flags_q.crit), .next(nxt.crit));

    tsense_limit_cmp #(.BELOW(1'b0), .W(CODE_W)) u_hi (
        .temp(smp_code), .limit(hi_lim), .hyst_code(cfg.hyst),
        .prev(flags_q.hi), .next(nxt.hi));

    tsense_limit_cmp #(.BELOW(1'b1), .W(CODE_W)) u_lo (
        .temp(smp_code), .limit(lo_lim), .hyst_code(cfg.hyst),
        .prev(flags_q.lo), .next(nxt.lo));

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q  <= '0;
            flags_q <= '0;
        end else if (accept) begin
            temp_q       <= smp_code;
            flags_q.crit <= nxt.crit;
            flags_q.hi   <= nxt.hi & ~cfg.crit_only;
            flags_q.lo   <= nxt.lo & ~cfg.crit_only;
        end
    end

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> temp_q == $past(smp_code));

    // R12
    shdn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.shdn |=> ($stable(temp_q) && $stable(flags_q)));

    // R8
    critonly_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cfg.crit_only) |=> (!flags_q.hi && !flags_q.lo));

endmodule

// File: rtl/tsense_read_mux.sv
module tsense_read_mux
    import tsense_pkg::*;
#(
    parameter logic [REG_W-1:0] MFG_ID    = 16'h5A17,
    parameter logic [REG_W-1:0] DEV_ID    = 16'h0C31,
    parameter bit               EXT_RANGE = 1'b1
) (
    input  logic [PTR_W-1:0]  addr,
    input  cfg_t              cfg,
    input  logic [CODE_W-1:0] hi_lim,
    input  logic [CODE_W-1:0] lo_lim,
    input  logic [CODE_W-1:0] crit_lim,
    input  logic [CODE_W-1:0] temp,
    input  flags_t            flags,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [REG_W-1:0] CAP_WORD = {13'b0, EXT_RANGE, 1'b0, 1'b1};

    always_comb begin
        case (ptr_e'(addr))
            PTR_CAP:  rdata = CAP_WORD;
            PTR_CFG:  rdata = cfg_word(cfg);
            PTR_HI:   rdata = lim_word(hi_lim);
            PTR_LO:   rdata = lim_word(lo_lim);
            PTR_CRIT: rdata = lim_word(crit_lim);
            PTR_TEMP: rdata = {flags.crit,
                               flags.hi & ~cfg.crit_only,
                               flags.lo & ~cfg.crit_only,
                               temp};
            PTR_MFG:  rdata = MFG_ID;
            default:  rdata = DEV_ID;
        endcase
    end

endmodule

// File: rtl/tsense_alarm_top.sv
module tsense_alarm_top
    import tsense_pkg::*;
#(
    parameter logic [15:0] MFG_ID    = 16'h5A17,
    parameter logic [15:0] DEV_ID    = 16'h0C31,
    parameter bit          EXT_RANGE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_valid,
    input  logic [12:0] sample_code,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        event_o
);

    cfg_t              cfg;
    flags_t            flags;
    logic [CODE_W-1:0] hi_lim;
    logic [CODE_W-1:0] lo_lim;
    logic [CODE_W-1:0] crit_lim;
    logic [CODE_W-1:0] temp;

    tsense_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cfg_q(cfg), .hi_q(hi_lim), .lo_q(lo_lim), .crit_q(crit_lim));

    tsense_alarm_eval u_eval (
        .clk(clk), .rst(rst), .smp_valid(sample_valid), .smp_code(sample_code),
        .cfg(cfg), .hi_lim(hi_lim), .lo_lim(lo_lim), .crit_lim(crit_lim),
        .temp_q(temp), .flags_q(flags));

    tsense_read_mux #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID), .EXT_RANGE(EXT_RANGE)) u_rmux (
        .addr(reg_addr), .cfg(cfg), .hi_lim(hi_lim), .lo_lim(lo_lim),
        .crit_lim(crit_lim), .temp(temp), .flags(flags), .rdata(reg_rdata));

    assign event_o = flags.crit | (~cfg.crit_only & (flags.hi | flags.lo));

    // R13
    event_critonly_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.crit_only && !flags.crit) |-> !event_o);

    // R13
    event_crit_chk: assert property (@(posedge clk) disable iff (rst)
        flags.crit |-> event_o);

endmodule

// File: tb/tsense_alarm_top_tb_top.sv
module tsense_alarm_top_tb_top;

    localparam logic [15:0] MFG = 16'h5A17;
    localparam logic [15:0] DEV = 16'h0C31;
    localparam logic [15:0] CAP_EXP = 16'h0005;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sv = 1'b0;
    logic [12:0] code = '0;
    logic        we = 1'b0;
    logic [2:0]  a = '0;
    logic [15:0] d = '0;
    logic [15:0] rdata;
    logic        ev;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tsense_alarm_top #(.MFG_ID(MFG), .DEV_ID(DEV), .EXT_RANGE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .sample_valid(sv), .sample_code(code),
        .reg_we(we), .reg_addr(a), .reg_wdata(d), .reg_rdata(rdata), .event_o(ev));

    // behavioural reference state
    logic [12:0] m_hi, m_lo, m_cr, m_t;
    bit m_co, m_sd, m_lc, m_lw, m_fc, m_fh, m_fl;
    logic [1:0] m_hy;

    function automatic int sx13(input logic [12:0] v);
        return v[12] ? int'(v) - 8192 : int'(v);
    endfunction

    function automatic int hys(input logic [1:0] c);
        int tab[4] = '{0, 24, 48, 96};
        return tab[c];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hi = '0; m_lo = '0; m_cr = '0; m_t = '0; m_hy = '0;
            m_co = 0; m_sd = 0; m_lc = 0; m_lw = 0; m_fc = 0; m_fh = 0; m_fl = 0;
        end else begin
            if (sv && !m_sd) begin
                int t, h;
                bit nc, nh, nl;
                t = sx13(code);
                h = hys(m_hy);
                nc = m_fc ? (t >= sx13(m_cr) - h) : (t >= sx13(m_cr));
                nh = m_fh ? (t >= sx13(m_hi) - h) : (t >= sx13(m_hi));
                nl = m_fl ? (t <  sx13(m_lo) + h) : (t <  sx13(m_lo));
                m_t = code;
                m_fc = nc;
                m_fh = nh && !m_co;
                m_fl = nl && !m_co;
            end
            if (we) begin
                case (a)
                    3'd1: begin
                        if (!m_lc && !m_lw) m_hy = d[10:9];
                        m_co = d[2];
                        m_sd = d[8];
                        m_lc = m_lc | d[6];
                        m_lw = m_lw | d[7];
                    end
                    3'd2: if (!m_lw) m_hi = d[12:0];
                    3'd3: if (!m_lw) m_lo = d[12:0];
                    3'd4: if (!m_lc) m_cr = d[12:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] m_read(input logic [2:0] p);
        case (p)
            3'd0: return CAP_EXP;
            3'd1: return {5'b0, m_hy, m_sd, m_lw, m_lc, 3'b0, m_co, 2'b0};
            3'd2: return {3'b0, m_hi};
            3'd3: return {3'b0, m_lo};
            3'd4: return {3'b0, m_cr};
            3'd5: return {m_fc, m_fh & !m_co, m_fl & !m_co, m_t};
            3'd6: return MFG;
            default: return DEV;
        endcase
    endfunction

    task automatic compare();
        logic [15:0] er;
        bit ee;
        er = m_read(a);
        ee = m_fc | (!m_co & (m_fh | m_fl));
        checks++;
        if (rdata !== er) begin
            errs++;
            $display("FAIL %s: reg %0d read %h expected %h", cur_req, a, rdata, er);
        end
        checks++;
        if (ev !== ee) begin
            errs++;
            $display("FAIL R13 (%s): event_o %b expected %b", cur_req, ev, ee);
        end
    endtask

    // one clock: check current outputs, then drive next inputs
    task automatic step(input bit w, input logic [2:0] p, input logic [15:0] wd,
                        input bit s, input int t);
        @(negedge clk);
        compare();
        we = w; a = p; d = wd; sv = s; code = 13'(t);
    endtask

    task automatic wr(input logic [2:0] p, input logic [15:0] wd);
        step(1'b1, p, wd, 1'b0, 0);
    endtask

    task automatic rd(input logic [2:0] p);
        step(1'b0, p, 16'h0, 1'b0, 0);
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) rd(3'(i));
        rd(3'd0);
    endtask

    task automatic sweep(input int from, input int to, input int stp);
        if (stp > 0) for (int v = from; v <= to; v += stp) step(1'b0, 3'd5, 16'h0, 1'b1, v);
        else         for (int v = from; v >= to; v += stp) step(1'b0, 3'd5, 16'h0, 1'b1, v);
        rd(3'd5);
    endtask

    function automatic logic [15:0] lim(input int v);
        return {3'b0, 13'(v)};
    endfunction

    initial begin
        // R1: reset values across the whole map
        cur_req = "R1";
        repeat (3) @(posedge clk);
        for (int i = 0; i < 8; i++) rd(3'(i));
        @(negedge clk);
        rst = 1'b0;
        read_all();

        // R2: read-only pointers and reserved bits
        cur_req = "R2";
        wr(3'd0, 16'hFFFF); wr(3'd5, 16'hFFFF); wr(3'd6, 16'h0000); wr(3'd7, 16'hFFFF);
        wr(3'd1, 16'hF83B);
        wr(3'd2, 16'hE000); wr(3'd3, 16'hFFFF); wr(3'd4, 16'h7ABC);
        read_all();

        // R3 R4 R5 R6: basic ramps, zero hysteresis
        cur_req = "R3";
        wr(3'd1, 16'h0000);
        wr(3'd2, lim(1280)); wr(3'd3, lim(160)); wr(3'd4, lim(1520));
        sweep(100, 1600, 60);
        cur_req = "R4";
        sweep(1540, 1500, -4);
        cur_req = "R5";
        sweep(1300, 1260, -4);
        cur_req = "R6";
        sweep(300, 100, -20);
        sweep(100, 300, 20);

        // R7: each hysteresis code, through upper/critical and lower bands
        for (int hc = 0; hc < 4; hc++) begin
            cur_req = "R7";
            wr(3'd1, 16'(hc << 9));
            rd(3'd1);
            sweep(1200, 1600, 8);
            sweep(1600, 1150, -4);
            sweep(260, 40, -8);
            sweep(40, 300, 4);
        end

        // R6 R7: signed comparison with negative limit and samples
        cur_req = "R6";
        wr(3'd1, 16'(1 << 9));
        wr(3'd3, lim(-160));
        sweep(200, -400, -25);
        sweep(-400, 100, 5);
        wr(3'd3, lim(160));

        // R8: critical-only mode
        cur_req = "R8";
        sweep(100, 1300, 100);
        wr(3'd1, 16'h0004);
        rd(3'd5);
        sweep(1300, 1600, 20);
        sweep(1600, 50, -50);
        wr(3'd1, 16'h0000);
        sweep(50, 1300, 50);

        // R12: shutdown holds value and flags
        cur_req = "R12";
        sweep(900, 1700, 400);
        wr(3'd1, 16'h0100);
        sweep(0, 200, 40);
        sweep(-500, -400, 50);
        wr(3'd1, 16'h0000);
        sweep(150, 250, 50);

        // R10: window lock, hysteresis freeze
        cur_req = "R10";
        wr(3'd1, 16'h0080 | 16'(1 << 9));
        rd(3'd1);
        wr(3'd1, 16'h0080 | 16'(3 << 9));
        rd(3'd1);
        wr(3'd2, lim(400)); wr(3'd3, lim(20));
        wr(3'd4, lim(1500));
        read_all();

        // R9: critical lock
        cur_req = "R9";
        wr(3'd1, 16'h00C0);
        wr(3'd4, lim(500));
        rd(3'd4);
        sweep(1400, 1560, 8);
        sweep(1560, 1440, -4);

        // R11: locks survive clearing writes, leave with reset
        cur_req = "R11";
        wr(3'd1, 16'h0000);
        rd(3'd1);
        wr(3'd2, lim(600)); wr(3'd4, lim(600));
        read_all();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        compare();
        rst = 1'b0;
        rd(3'd1);
        wr(3'd2, lim(600)); wr(3'd4, lim(700));
        wr(3'd1, 16'(2 << 9));
        read_all();
        cur_req = "R13";
        sweep(500, 800, 20);
        sweep(800, 400, -20);
        rd(3'd5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule